// File: doc/BRIEF.md
# Byte FIFO with Sacrificed Slot

This block is a single-clock first-in first-out queue for 8-bit characters, for example the bytes going to or coming from a serial port. The storage is an inferred simple dual-port memory. One port only writes and the other only reads. A write pointer selects where an incoming byte goes, and a read pointer selects the head of the queue. The memory is read at the read pointer on every clock, and the result goes into an output register.

No occupancy counter exists. The fill state is decoded from the two pointers alone. Equal pointers mean the queue is empty. A write pointer one step behind the read pointer, modulo the depth, means the queue is full. As a result, a memory with 2^ADDR_W locations holds at most 2^ADDR_W - 1 bytes.

The decoded fill state is an enumeration with three states:
- `FS_EMPTY`: the pointers are equal.
- `FS_PARTIAL`: neither empty nor full.
- `FS_FULL`: the write pointer plus one equals the read pointer.

The transitions are:
- EMPTY to PARTIAL on an accepted write.
- PARTIAL to FULL when a write takes the last free slot.
- FULL to PARTIAL on an accepted read.
- PARTIAL to EMPTY when a read takes the last entry.
- Any state to EMPTY on reset.
- Every state holds when an accepted read and an accepted write fall in the same cycle.

Top module: `byte_fifo`

## Requirements
- R1: A synchronous reset, sampled at a rising clock edge, sets both pointers to zero. After that edge, empty=1, full=0 and dout=8'h00, whatever the memory holds.
- R2: Bytes leave the queue in the order they were accepted, with none lost and none duplicated.
- R3: empty is 1 exactly when the read and write pointers are equal. A read request while empty is ignored and leaves empty at 1.
- R4: With the default ADDR_W=12, full rises after 4095 accepted writes and not after 4094. A write request while full is ignored and its byte never appears at dout.
- R5: When a read and a write are both accepted in one cycle, both pointers advance and empty and full stay unchanged. While empty only the write is accepted, and while full only the read is accepted.
- R6: Each pointer wraps from the last location (4095) to 0, and order is kept across the wrap.
- R7: dout is registered. It shows the memory word at the read pointer as it was before the latest clock edge. A new head appears one edge after the read pointer reaches it, and a freshly written byte appears one edge after the write that stored it.
- R8: The write port is read-first. If the read pointer addresses the location being written, dout after that edge shows the location's previous contents.
- R9: full and empty are never asserted together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| we | input | 1 | Write request |
| re | input | 1 | Read request |
| din | input | 8 | Byte to enqueue |
| dout | output | 8 | Registered memory word at the read pointer |
| full | output | 1 | Queue holds 2^ADDR_W - 1 bytes |
| empty | output | 1 | Queue holds no byte |

## Verification
A write and a read can be requested in the same cycle. What happens then depends on the decoded state. In the partial state both are accepted and the flags must not move. In the empty state only the write is taken, and in the full state only the read. The bench raises both requests together once while empty and once while full. It judges the result from the flags after that edge and from the exact sequence of bytes drained afterwards: a dropped write or a skipped read shows up as an order mismatch or a wrong final empty. A second coincidence is a write landing on the very address being read. After a reset over old contents, the bench expects the old byte first and the new one an edge later.

// File: rtl/byte_fifo_pkg.sv
package byte_fifo_pkg;

    // Fill state decoded from the two pointers
    typedef enum logic [1:0] {
        FS_EMPTY   = 2'd0,
        FS_PARTIAL = 2'd1,
        FS_FULL    = 2'd2
    } fill_state_t;

endpackage

// File: rtl/byte_fifo_ptr.sv
module byte_fifo_ptr #(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              adv,
    output logic [ADDR_W-1:0] ptr,
    output logic [ADDR_W-1:0] ptr_inc
);

    localparam logic [ADDR_W-1:0] LAST = {ADDR_W{1'b1}};

    assign ptr_inc = ptr + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
        end else if (adv) begin
            ptr <= ptr_inc;
        end
    end

    AST_PTR_WRAP: assert property (@(posedge clk) disable iff (rst)
        (adv && ptr == LAST) |=> (ptr == '0)); // R6

    AST_PTR_HOLD: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(ptr)); // R3

endmodule

// File: rtl/byte_fifo_ram.sv
module byte_fifo_ram #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Write port: no reset, contents survive rst
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    // Read port: sampled every cycle, old word on a colliding write
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
        end else begin
            rd_data <= mem[rd_addr];
        end
    end

endmodule

// File: rtl/byte_fifo.sv
module byte_fifo
    import byte_fifo_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic              re,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              full,
    output logic              empty
);

    logic [ADDR_W-1:0] wr_ptr, wr_ptr_inc;
    logic [ADDR_W-1:0] rd_ptr, rd_ptr_inc;
    logic              wr_acc, rd_acc;
    fill_state_t       fill_st;

    byte_fifo_ptr #(.ADDR_W(ADDR_W)) u_wr_ptr (
        .clk     (clk),
        .rst     (rst),
        .adv     (wr_acc),
        .ptr     (wr_ptr),
        .ptr_inc (wr_ptr_inc)
    );

    byte_fifo_ptr #(.ADDR_W(ADDR_W)) u_rd_ptr (
        .clk     (clk),
        .rst     (rst),
        .adv     (rd_acc),
        .ptr     (rd_ptr),
        .ptr_inc (rd_ptr_inc)
    );

    byte_fifo_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_acc),
        .wr_addr (wr_ptr),
        .wr_data (din),
        .rd_addr (rd_ptr),
        .rd_data (dout)
    );

    // Fill state decode from pointer comparison only
    always_comb begin
        if (rd_ptr == wr_ptr) begin
            fill_st = FS_EMPTY;
        end else if (wr_ptr_inc == rd_ptr) begin
            fill_st = FS_FULL;
        end else begin
            fill_st = FS_PARTIAL;
        end
    end

    // Per-state outputs and request acceptance
    always_comb begin
        empty  = 1'b0;
        full   = 1'b0;
        wr_acc = 1'b0;
        rd_acc = 1'b0;
        unique case (fill_st)
            FS_EMPTY: begin
                empty  = 1'b1;
                wr_acc = we;
            end
            FS_FULL: begin
                full   = 1'b1;
                rd_acc = re;
            end
            FS_PARTIAL: begin
                wr_acc = we;
                rd_acc = re;
            end
            default: begin
                empty = 1'b1;
            end
        endcase
    end

    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(full && empty)); // R9

    AST_EMPTY_READ_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (empty && re && !we) |=> empty); // R3

    AST_FULL_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (full && we && !re) |=> full); // R4

    AST_BOTH_KEEP_FLAGS: assert property (@(posedge clk) disable iff (rst)
        (we && re && !full && !empty) |=> ($stable(full) && $stable(empty))); // R5

    AST_WRITE_FILLS: assert property (@(posedge clk) disable iff (rst)
        (we && !full) |=> !empty); // R2

endmodule

// File: tb/byte_fifo_tb.sv
module byte_fifo_tb;

    localparam int CLK_PERIOD = 10;
    localparam int CAP        = 4095;

    typedef struct packed {
        logic       we;
        logic       re;
        logic [7:0] din;
        logic       exp_empty;
        logic       exp_full;
        logic       chk_dout;
        logic [7:0] exp_dout;
    } vec_t;

    // Sequence from reset; the flag and dout columns give the state after each edge
    localparam int NVEC = 10;
    localparam vec_t VECS [NVEC] = '{
        '{1'b1, 1'b0, 8'hA1, 1'b0, 1'b0, 1'b0, 8'h00}, // R3 write leaves empty
        '{1'b1, 1'b0, 8'hA2, 1'b0, 1'b0, 1'b1, 8'hA1}, // R7 head appears one edge later
        '{1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 8'hA1}, // R7 idle hold
        '{1'b0, 1'b1, 8'h00, 1'b0, 1'b0, 1'b1, 8'hA1}, // R2 pop first
        '{1'b1, 1'b1, 8'hA3, 1'b0, 1'b0, 1'b1, 8'hA2}, // R5 both accepted
        '{1'b0, 1'b1, 8'h00, 1'b1, 1'b0, 1'b1, 8'hA3}, // R3 drained
        '{1'b0, 1'b1, 8'h00, 1'b1, 1'b0, 1'b0, 8'h00}, // R3 read while empty
        '{1'b1, 1'b1, 8'hA4, 1'b0, 1'b0, 1'b0, 8'h00}, // R5 only write taken
        '{1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 8'hA4}, // R7
        '{1'b0, 1'b1, 8'h00, 1'b1, 1'b0, 1'b1, 8'hA4}  // R2
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       we  = 1'b0;
    logic       re  = 1'b0;
    logic [7:0] din = 8'h00;
    logic [7:0] dout;
    logic       full, empty;

    int checks = 0;
    int errors = 0;
    logic [7:0] q [$];

    byte_fifo u_dut (
        .clk   (clk),
        .rst   (rst),
        .we    (we),
        .re    (re),
        .din   (din),
        .dout  (dout),
        .full  (full),
        .empty (empty)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // One clock edge; returns at the following falling edge
    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1; we = 1'b0; re = 1'b0;
        cyc();
        rst = 1'b0;
    endtask

    task automatic drain(input int n, input string req);
        for (int k = 0; k < n; k++) begin
            we = 1'b0; re = 1'b0;
            cyc();
            check(req, "dout order", 32'(dout), 32'(q[0]));
            re = 1'b1;
            cyc();
            re = 1'b0;
            void'(q.pop_front());
        end
        check(req, "empty after drain", 32'(empty), 32'd1);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();
        check("R1", "empty", 32'(empty), 32'd1);
        check("R1", "full", 32'(full), 32'd0);
        check("R1", "dout", 32'(dout), 32'd0);

        // Vector table walk
        for (int v = 0; v < NVEC; v++) begin
            we = VECS[v].we; re = VECS[v].re; din = VECS[v].din;
            cyc();
            check("R3", $sformatf("vec %0d empty", v), 32'(empty), 32'(VECS[v].exp_empty));
            check("R4", $sformatf("vec %0d full", v), 32'(full), 32'(VECS[v].exp_full));
            if (VECS[v].chk_dout)
                check("R7", $sformatf("vec %0d dout", v), 32'(dout), 32'(VECS[v].exp_dout));
        end
        we = 1'b0; re = 1'b0;

        // Fill to capacity
        do_reset();
        for (int i = 0; i < CAP; i++) begin
            we = 1'b1; din = 8'(i ^ 32'h5A);
            q.push_back(din);
            cyc();
            if (i == CAP - 2) check("R4", "not full at 4094", 32'(full), 32'd0);
        end
        we = 1'b0;
        check("R4", "full at 4095", 32'(full), 32'd1);
        check("R9", "empty low when full", 32'(empty), 32'd0);

        // Write while full is dropped
        we = 1'b1; din = 8'hEE;
        cyc();
        we = 1'b0;
        check("R4", "full holds after dropped write", 32'(full), 32'd1);

        // Read and write together while full: only the read is taken
        we = 1'b1; re = 1'b1; din = 8'hDD;
        cyc();
        we = 1'b0; re = 1'b0;
        void'(q.pop_front());
        check("R5", "full drops after read", 32'(full), 32'd0);
        check("R5", "not empty", 32'(empty), 32'd0);
        drain(CAP - 1, "R2");

        // Pointers now at 4095: write across the wrap
        we = 1'b1; din = 8'hB1; q.push_back(din); cyc();
        din = 8'hB2; q.push_back(din); cyc();
        we = 1'b0;
        drain(2, "R6");

        // Reset over stale contents, then a colliding write
        do_reset();
        check("R1", "empty after reset", 32'(empty), 32'd1);
        check("R1", "dout after reset", 32'(dout), 32'd0);
        we = 1'b1; din = 8'h3C;
        cyc();
        we = 1'b0;
        check("R8", "old word on collision", 32'(dout), 32'hB2);
        check("R3", "empty clears", 32'(empty), 32'd0);
        cyc();
        check("R7", "new word one edge later", 32'(dout), 32'h3C);

        // Reset while holding an entry
        do_reset();
        check("R1", "empty after mid reset", 32'(empty), 32'd1);
        check("R1", "full after mid reset", 32'(full), 32'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule